// File: doc/BRIEF.md
# Receiver Power Mode Controller

This block decides which power state a video receiver runs in and turns that state into per-domain enables and output high-impedance controls. Three sources feed it. The first is an active-low power-down control bit. The second is an external power-down pin whose polarity software can program. The third is a set of sync activity flags, read together with an auto power-down enable. A software command to power down always wins. If no command is present, an asserted pin can either shut the chip down to one of four retention depths or only float the outputs. If the pin is not asserted, sync activity and the auto enable choose between full power, seek and auto power-down.

All control inputs arrive as plain parallel values from a register file. The activity flags are already synchronous to `clk`. The external pin is asynchronous and passes through a synchronizer before its polarity is applied. Every output is registered.

Top module: `rx_power_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released until the next clock edge, `pwr_state` is 2'b11, `dom_en` is 8'h0F and all four high-impedance outputs are 1.
- R2: `pwr_state` uses the encoding 2'b00 full power, 2'b01 seek, 2'b10 auto power-down and 2'b11 power-down. The `dom_en` bits mean: bit0 control interface, bit1 sync activity detect, bit2 sync-on-green path, bit3 reference, bit4 analog front end, bit5 clock generation, bit6 digital receiver, bit7 output formatter.
- R3: When `pd_ctl_n` is 0, the next state is 2'b11 with `dom_en` 8'h0F. This holds whatever the activity flags, `auto_pd_en` and the pin are.
- R4: Sync is detected when any of `act_status[7:2]` is 1. Bits 1:0 of `act_status` have no effect.
- R5: When `pd_ctl_n` is 1, sync is detected and the pin is not requesting power-down, the state is 2'b00 with `dom_en` 8'hFF.
- R6: When `pd_ctl_n` is 1, no sync is detected, the pin is not requesting power-down and `auto_pd_en` is 0, the state is 2'b01 with `dom_en` 8'hFF.
- R7: Under the same conditions as R6 but with `auto_pd_en` at 1, the state is 2'b10 with `dom_en` 8'h0F.
- R8: The pin is asserted when it is high if `pd_cfg[3]` is 1, and when it is low if `pd_cfg[3]` is 0. A change on the pin reaches the outputs at the third rising clock edge after it.
- R9: When `pd_cfg[0]` is 0, `pd_ctl_n` is 1 and the pin is asserted, the state is 2'b11. `dom_en` is then chosen by `pd_cfg[2:1]`: 00 gives 8'h0F, 01 gives 8'h0B, 10 gives 8'h03 and 11 gives 8'h01.
- R10: When `pd_cfg[0]` is 1, the asserted pin leaves the state and `dom_en` as R3 to R7 decide. It drives `data_z`, `spdif_z` and `i2s_z` to 1 and leaves `sog_z` unchanged.
- R11: `pd_cfg[7]`, `pd_cfg[6]`, `pd_cfg[5]` and `pd_cfg[4]` each force `data_z`, `sog_z`, `spdif_z` and `i2s_z` to 1, in that pairing.
- R12: Inputs other than the pin take effect at the first rising edge after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_ctl_n | input | 1 | Power-down command, 0 requests power-down |
| pd_pin | input | 1 | Asynchronous external power-down pin |
| act_status | input | 8 | Activity status byte, flags in bits 7:2 |
| auto_pd_en | input | 1 | Enables auto power-down without sync |
| pd_cfg | input | 8 | Pin polarity, pin action, pin depth, tri-state forces |
| pwr_state | output | 2 | Current power state code |
| dom_en | output | 8 | Per-domain power enables |
| data_z | output | 1 | Pixel data outputs in high impedance |
| sog_z | output | 1 | Sync-on-green output in high impedance |
| spdif_z | output | 1 | S/PDIF output in high impedance |
| i2s_z | output | 1 | I2S output in high impedance |

## Verification
A wrong priority or a wrong state decode shows one edge after the inputs settle, either as a state code that does not match or as a domain mask that is too wide or too narrow. A domain mask that is too narrow in full power or seek shuts down live circuitry. Mistakes in the pin path show up later, three edges after the pin changes. They appear as a wrong polarity, an off-by-one depth mask, or the tri-state action leaking into the state or into `sog_z`. The bench therefore checks latency cycle by cycle on both paths, and compares every mask against a value it computes itself.

// File: rtl/rx_pwr_pkg.sv
package rx_pwr_pkg;

   typedef enum logic [1:0] {
      PS_FULL = 2'b00,
      PS_SEEK = 2'b01,
      PS_AUTO = 2'b10,
      PS_DOWN = 2'b11
   } pwr_state_e;

   localparam int DOM_W = 8;

   localparam int DOM_CTRL  = 0;
   localparam int DOM_ACT   = 1;
   localparam int DOM_SOG   = 2;
   localparam int DOM_REF   = 3;
   localparam int DOM_AFE   = 4;
   localparam int DOM_CLK   = 5;
   localparam int DOM_RX    = 6;
   localparam int DOM_OUTF  = 7;

   typedef enum logic [1:0] {
      DM_ALL  = 2'b00,
      DM_STD  = 2'b01,
      DM_PIN  = 2'b10
   } dom_mode_e;

   // Domains that stay alive for a given retention depth.
   function automatic logic keep_dom(input int idx, input dom_mode_e mode,
                                     input logic [1:0] depth);
      logic k;
      k = 1'b0;
      case (mode)
         DM_ALL: k = 1'b1;
         DM_STD: k = (idx == DOM_CTRL) || (idx == DOM_ACT) ||
                     (idx == DOM_SOG)  || (idx == DOM_REF);
         DM_PIN: begin
            case (depth)
               2'b00: k = (idx == DOM_CTRL) || (idx == DOM_ACT) ||
                          (idx == DOM_SOG)  || (idx == DOM_REF);
               2'b01: k = (idx == DOM_CTRL) || (idx == DOM_ACT) ||
                          (idx == DOM_REF);
               2'b10: k = (idx == DOM_CTRL) || (idx == DOM_ACT);
               default: k = (idx == DOM_CTRL);
            endcase
         end
         default: k = 1'b0;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/rx_pwr_pin_sync.sv
module rx_pwr_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rx_pwr_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/rx_pwr_state_sel.sv
module rx_pwr_state_sel
   import rx_pwr_pkg::*;
#(
   parameter int STAT_W  = 8,
   parameter int ACT_LSB = 2
) (
   input  logic              cmd_pd_n,
   input  logic [STAT_W-1:0] status,
   input  logic              auto_en,
   input  logic              pin_act,
   input  logic              pin_tri_mode,
   output pwr_state_e        nxt_state,
   output dom_mode_e         nxt_mode,
   output logic              pin_tri,
   output logic              sync_det
);
   localparam int ACT_W = STAT_W - ACT_LSB;

   if (ACT_LSB < 1 || ACT_W < 1) begin : g_bad_slice
      $error("rx_pwr_state_sel: activity slice out of range");
   end

   logic unused_status_low;
   assign unused_status_low = ^status[ACT_LSB-1:0];

   assign sync_det = |status[STAT_W-1:ACT_LSB];
   assign pin_tri  = pin_act & pin_tri_mode;

   // Priority: command, pin power-down, sync activity, auto enable.
   always_comb begin
      nxt_state = PS_DOWN;
      nxt_mode  = DM_STD;
      if (!cmd_pd_n) begin
         nxt_state = PS_DOWN;
         nxt_mode  = DM_STD;
      end else if (pin_act && !pin_tri_mode) begin
         nxt_state = PS_DOWN;
         nxt_mode  = DM_PIN;
      end else if (sync_det) begin
         nxt_state = PS_FULL;
         nxt_mode  = DM_ALL;
      end else if (!auto_en) begin
         nxt_state = PS_SEEK;
         nxt_mode  = DM_ALL;
      end else begin
         nxt_state = PS_AUTO;
         nxt_mode  = DM_STD;
      end
   end
endmodule

// File: rtl/rx_pwr_dom_map.sv
module rx_pwr_dom_map
   import rx_pwr_pkg::*;
#(
   parameter int NDOM = DOM_W
) (
   input  dom_mode_e       mode,
   input  logic [1:0]      depth,
   output logic [NDOM-1:0] en
);
   if (NDOM != DOM_W) begin : g_bad_ndom
      $error("rx_pwr_dom_map: NDOM must match the package domain count");
   end

   for (genvar d = 0; d < NDOM; d++) begin : g_dom
      assign en[d] = keep_dom(d, mode, depth);
   end
endmodule

// File: rtl/rx_power_mode_ctrl.sv
module rx_power_mode_ctrl
   import rx_pwr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int STAT_W      = 8,
   parameter int ACT_LSB     = 2,
   parameter int CFG_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd_ctl_n,
   input  logic              pd_pin,
   input  logic [STAT_W-1:0] act_status,
   input  logic              auto_pd_en,
   input  logic [CFG_W-1:0]  pd_cfg,
   output logic [1:0]        pwr_state,
   output logic [DOM_W-1:0]  dom_en,
   output logic              data_z,
   output logic              sog_z,
   output logic              spdif_z,
   output logic              i2s_z
);
   localparam int CFG_TRI_MODE = 0;
   localparam int CFG_DEPTH_LO = 1;
   localparam int CFG_POL      = 3;
   localparam int CFG_Z_I2S    = 4;
   localparam int CFG_Z_SPDIF  = 5;
   localparam int CFG_Z_SOG    = 6;
   localparam int CFG_Z_DATA   = 7;
   localparam logic [DOM_W-1:0] RST_EN = 8'h0F;

   if (CFG_W != 8) begin : g_bad_cfg
      $error("rx_power_mode_ctrl: configuration width must be 8");
   end

   logic       pin_sync;
   logic       pin_act;
   logic       pin_tri;
   logic       sync_det;
   pwr_state_e nxt_state;
   dom_mode_e  nxt_mode;
   logic [DOM_W-1:0] nxt_en;

   pwr_state_e       state_q;
   logic [DOM_W-1:0] en_q;
   logic             data_z_q, sog_z_q, spdif_z_q, i2s_z_q;

   rx_pwr_pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pd_pin),
      .sync_out (pin_sync)
   );

   assign pin_act = pd_cfg[CFG_POL] ? pin_sync : ~pin_sync;

   rx_pwr_state_sel #(.STAT_W(STAT_W), .ACT_LSB(ACT_LSB)) u_sel (
      .cmd_pd_n     (pd_ctl_n),
      .status       (act_status),
      .auto_en      (auto_pd_en),
      .pin_act      (pin_act),
      .pin_tri_mode (pd_cfg[CFG_TRI_MODE]),
      .nxt_state    (nxt_state),
      .nxt_mode     (nxt_mode),
      .pin_tri      (pin_tri),
      .sync_det     (sync_det)
   );

   rx_pwr_dom_map #(.NDOM(DOM_W)) u_map (
      .mode  (nxt_mode),
      .depth (pd_cfg[CFG_DEPTH_LO+1:CFG_DEPTH_LO]),
      .en    (nxt_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= PS_DOWN;
         en_q      <= RST_EN;
         data_z_q  <= 1'b1;
         sog_z_q   <= 1'b1;
         spdif_z_q <= 1'b1;
         i2s_z_q   <= 1'b1;
      end else begin
         state_q   <= nxt_state;
         en_q      <= nxt_en;
         data_z_q  <= pd_cfg[CFG_Z_DATA]  | pin_tri;
         sog_z_q   <= pd_cfg[CFG_Z_SOG];
         spdif_z_q <= pd_cfg[CFG_Z_SPDIF] | pin_tri;
         i2s_z_q   <= pd_cfg[CFG_Z_I2S]   | pin_tri;
      end
   end

   assign pwr_state = state_q;
   assign dom_en    = en_q;
   assign data_z    = data_z_q;
   assign sog_z     = sog_z_q;
   assign spdif_z   = spdif_z_q;
   assign i2s_z     = i2s_z_q;

   AST_CMD_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_ctl_n |=> (pwr_state == 2'b11 && dom_en == 8'h0F)); // R3

   AST_SYNC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_ctl_n && sync_det && !(pin_act && !pd_cfg[CFG_TRI_MODE]))
      |=> (pwr_state == 2'b00)); // R5

   AST_LIVE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'b00 || pwr_state == 2'b01) |-> (&dom_en)); // R6

   AST_LOW_AFE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'b10 || pwr_state == 2'b11) |-> (dom_en[7:4] == 4'h0)); // R9

   AST_CTRL_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
      dom_en[0]); // R2

   AST_SOG_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      pd_cfg[CFG_Z_SOG] |=> sog_z); // R11

   AST_PIN_TRI_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_act && pd_cfg[CFG_TRI_MODE]) |=> (data_z && spdif_z && i2s_z)); // R10

endmodule

// File: tb/rx_power_mode_ctrl_bench.sv
module rx_power_mode_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pd_ctl_n = 1'b1;
   logic       pd_pin = 1'b0;
   logic [7:0] act_status = 8'h00;
   logic       auto_pd_en = 1'b0;
   logic [7:0] pd_cfg = 8'h08;
   logic [1:0] pwr_state;
   logic [7:0] dom_en;
   logic       data_z, sog_z, spdif_z, i2s_z;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   rx_power_mode_ctrl u_rx_power_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .pd_ctl_n(pd_ctl_n), .pd_pin(pd_pin),
      .act_status(act_status), .auto_pd_en(auto_pd_en), .pd_cfg(pd_cfg),
      .pwr_state(pwr_state), .dom_en(dom_en), .data_z(data_z),
      .sog_z(sog_z), .spdif_z(spdif_z), .i2s_z(i2s_z)
   );

   task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] pack_out();
      return {pwr_state, dom_en, data_z, sog_z};
   endfunction

   function automatic logic [3:0] zs();
      return {data_z, sog_z, spdif_z, i2s_z};
   endfunction

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 reset state/en", {pwr_state, dom_en, 2'b00}, {2'b11, 8'h0F, 2'b00});
      check("R1 reset tri", {8'h00, zs()}, {8'h00, 4'hF});
      rst_n = 1'b1;
      #1;
      check("R1 after release", {pwr_state, dom_en, 2'b00}, {2'b11, 8'h0F, 2'b00});
   endtask

   task automatic t_cmd_priority();
      pd_ctl_n = 1'b0; act_status = 8'hFC; auto_pd_en = 1'b0; pd_cfg = 8'h08; pd_pin = 1'b0;
      settle();
      check("R3 cmd pd with sync", {pwr_state, dom_en, 2'b00}, {2'b11, 8'h0F, 2'b00});
      pd_cfg = 8'h0E; pd_pin = 1'b1;
      settle();
      check("R3 cmd pd over pin depth", {pwr_state, dom_en, 2'b00}, {2'b11, 8'h0F, 2'b00});
      pd_pin = 1'b0; pd_cfg = 8'h08;
   endtask

   task automatic t_sync_states();
      pd_ctl_n = 1'b1; auto_pd_en = 1'b1;
      for (int b = 2; b < 8; b++) begin
         act_status = 8'h01 << b;
         settle();
         check("R5 full on single flag", {pwr_state, dom_en, 2'b00}, {2'b00, 8'hFF, 2'b00});
      end
      act_status = 8'h03;
      settle();
      check("R4 low bits ignored, R7 auto", {pwr_state, dom_en, 2'b00}, {2'b10, 8'h0F, 2'b00});
      auto_pd_en = 1'b0;
      settle();
      check("R6 seek", {pwr_state, dom_en, 2'b00}, {2'b01, 8'hFF, 2'b00});
   endtask

   task automatic t_latency();
      pd_ctl_n = 1'b1; act_status = 8'h00; auto_pd_en = 1'b0; pd_cfg = 8'h08; pd_pin = 1'b0;
      settle();
      @(negedge clk);
      act_status = 8'h80;
      #1;
      check("R12 no change before edge", {10'h000, pwr_state}, {10'h000, 2'b01});
      @(negedge clk);
      check("R12 change after one edge", {10'h000, pwr_state}, {10'h000, 2'b00});
   endtask

   task automatic t_pin_polarity();
      pd_ctl_n = 1'b1; act_status = 8'h80; auto_pd_en = 1'b0;
      pd_cfg = 8'h08; pd_pin = 1'b0;
      settle();
      check("R8 high-active idle", {10'h000, pwr_state}, {10'h000, 2'b00});
      @(negedge clk);
      pd_pin = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R8 two edges still old", {10'h000, pwr_state}, {10'h000, 2'b00});
      @(negedge clk);
      check("R8 third edge new", {pwr_state, dom_en, 2'b00}, {2'b11, 8'h0F, 2'b00});
      pd_cfg = 8'h00; pd_pin = 1'b1;
      settle();
      check("R8 low-active pin high idle", {10'h000, pwr_state}, {10'h000, 2'b00});
      pd_pin = 1'b0;
      settle();
      check("R8 low-active pin low", {10'h000, pwr_state}, {10'h000, 2'b11});
   endtask

   task automatic t_pin_depth();
      logic [7:0] expm [4] = '{8'h0F, 8'h0B, 8'h03, 8'h01};
      pd_ctl_n = 1'b1; act_status = 8'h80; pd_pin = 1'b1;
      for (int d = 0; d < 4; d++) begin
         pd_cfg = {4'h0, 1'b1, d[1:0], 1'b0};
         settle();
         check("R9 pin depth", {pwr_state, dom_en, 2'b00}, {2'b11, expm[d], 2'b00});
      end
   endtask

   task automatic t_pin_tristate();
      pd_ctl_n = 1'b1; act_status = 8'h80; pd_pin = 1'b1; pd_cfg = 8'h09;
      settle();
      check("R10 state kept", {pwr_state, dom_en, 2'b00}, {2'b00, 8'hFF, 2'b00});
      check("R10 outputs floated", {8'h00, zs()}, {8'h00, 4'b1011});
      pd_pin = 1'b0;
      settle();
      check("R10 release", {8'h00, zs()}, {8'h00, 4'b0000});
   endtask

   task automatic t_forces();
      pd_ctl_n = 1'b1; act_status = 8'h80; pd_pin = 1'b0;
      for (int k = 0; k < 4; k++) begin
         pd_cfg = 8'h08 | (8'h10 << k);
         settle();
         check("R11 force bit", {8'h00, zs()}, {8'h00, 4'b0001 << k});
      end
      pd_cfg = 8'h08;
   endtask

   initial begin
      #1000000;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_cmd_priority();
      t_sync_states();
      t_latency();
      t_pin_polarity();
      t_pin_depth();
      t_pin_tristate();
      t_forces();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule